// File: doc/BRIEF.md
# Range-Weight Photometric Pipeline

This block is the edge-preserving stage of a denoising filter that works on a 5x5 window. A window-forming block upstream delivers the 24 neighbours of a centre pixel as six lanes of four pixels each. It sends one slot per cycle, so one window takes four internal cycles. On the first slot of a window, the centre pixel comes in alongside the lanes and is held for the rest of that window.

Each of the six identical lanes does three things with its neighbour:
- it takes the absolute gray-level distance to the held centre;
- it converts that distance into a range coefficient through a constant table, so no exponential is evaluated;
- it multiplies the neighbour by that coefficient.

The block outputs the weighted pixels and the coefficients of all six lanes, together with the centre pixel weighted by full scale. All of these are aligned and come out a fixed number of cycles after the input. A spatial weighting stage downstream accumulates them.

The table holds one entry per possible distance. It is filled at elaboration from a decay rule: the full-scale value is halved once for every `LUT_SHIFT`-wide step of distance, and the entry is zero once the number of halvings reaches the coefficient width.

Top module: `range_weight_pipe`

## Requirements
- R1: The centre pixel is captured on a cycle where `valid_i` and `first_i` are both high, and that same cycle uses it directly. The three following slots use the captured value, and `center_i` has no effect on them.
- R2: The coefficient depends only on the absolute distance. A neighbour at centre+d and one at centre-d get equal coefficients.
- R3: The coefficient for distance d is (2^COEF_W-1) >> (d >> LUT_SHIFT), and 0 when (d >> LUT_SHIFT) >= COEF_W. Distance 0 gives 2^COEF_W-1, and the values never rise as d grows (defaults 8-bit and 4, so 255 at d=0 and 0 from d=128).
- R4: Each lane's weighted output is the unsigned product of its pixel and its coefficient, PIX_W+COEF_W bits wide, with no truncation.
- R5: The centre output equals centre × (2^COEF_W-1). It belongs to the window of the slot it accompanies.
- R6: Every output appears exactly 4 clock cycles after its slot is sampled, and `valid_o` repeats `valid_i` with the same 4-cycle delay.
- R7: Slots and windows may follow each other with no gap, one slot per cycle. A full 24-neighbour window is then finished every 4 cycles.
- R8: After reset, `valid_o` is low and all data outputs are zero.
- R9: Lane g occupies bits [g*PIX_W +: PIX_W] of `grp_pix_i`, bits [g*(PIX_W+COEF_W) +: PIX_W+COEF_W] of `wpix_o`, and bits [g*COEF_W +: COEF_W] of `coef_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal (4x pixel) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Slot present on inputs |
| first_i | input | 1 | Marks the first slot of a window; captures the centre |
| center_i | input | PIX_W | Centre pixel, used on the first slot |
| grp_pix_i | input | N_GRP*PIX_W | One neighbour per lane |
| valid_o | output | 1 | Outputs carry a result slot |
| wpix_o | output | N_GRP*(PIX_W+COEF_W) | Weighted neighbours per lane |
| coef_o | output | N_GRP*COEF_W | Range coefficients per lane |
| wcen_o | output | PIX_W+COEF_W | Centre pixel times full-scale coefficient |
| cen_coef_o | output | COEF_W | Coefficient of the centre, full scale |

## Verification
There are two likely internal faults. A stale or overwritten centre register shows up on every lane of slots 1 to 3 of a window, exactly four cycles after those slots, as coefficients that do not match distances to the true centre. A wrong table entry or a broken distance sign shows up on the lane and slot whose distance selects it. Mirrored patterns around the centre expose it, and so do pixels at the table edges (distance 0, one step, and beyond the last step). A dropped or extra pipeline stage moves `valid_o` and all data by a cycle, and the check on the output cycle of every slot catches it at the first result.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  // decaying range coefficient: full scale halved once per 2^sh distance step
  function automatic int range_coef(int d, int w, int sh);
    int steps;
    steps = d >>> sh;
    if (steps >= w) return 0;
    return ((1 << w) - 1) >>> steps;
  endfunction
endpackage

// File: rtl/rwp_lane.sv
module rwp_lane #(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 8,
  parameter int LUT_SHIFT = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PIX_W-1:0]          pix_i,
  input  logic [PIX_W-1:0]          cen_i,
  output logic [PIX_W+COEF_W-1:0]   wpix_o,
  output logic [COEF_W-1:0]         coef_o
);
  localparam int LUT_N = 1 << PIX_W;
  localparam int WP_W  = PIX_W + COEF_W;
  localparam logic [COEF_W-1:0] COEF_MAX = {COEF_W{1'b1}};
  localparam int ZERO_FROM = COEF_W << LUT_SHIFT;

  logic [PIX_W-1:0]  pix_a, cen_a, pix_b, pix_c, diff_b;
  logic [COEF_W-1:0] coef_c;
  logic [PIX_W-1:0]  diff_c;
  logic [COEF_W-1:0] lut [LUT_N];

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    assign lut[i] = COEF_W'(rwp_pkg::range_coef(i, COEF_W, LUT_SHIFT));
  end

  assign diff_c = (pix_a >= cen_a) ? pix_a - cen_a : cen_a - pix_a;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_a  <= '0;
      cen_a  <= '0;
      pix_b  <= '0;
      diff_b <= '0;
      pix_c  <= '0;
      coef_c <= '0;
      wpix_o <= '0;
      coef_o <= '0;
    end else begin
      pix_a  <= pix_i;
      cen_a  <= cen_i;
      pix_b  <= pix_a;
      diff_b <= diff_c;
      pix_c  <= pix_b;
      coef_c <= lut[diff_b];
      wpix_o <= WP_W'(pix_c) * WP_W'(coef_c);
      coef_o <= coef_c;
    end
  end

  assert_match_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_a == cen_a) |-> ##3 (coef_o == COEF_MAX));
  assert_far_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(diff_b) >= ZERO_FROM) |=> (coef_c == '0));
  assert_zero_coef_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_o == '0) |-> (wpix_o == '0));
endmodule

// File: rtl/rwp_centre.sv
module rwp_centre #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    first_i,
  input  logic [PIX_W-1:0]        center_i,
  output logic [PIX_W-1:0]        cen_o,
  output logic                    valid_o,
  output logic [PIX_W+COEF_W-1:0] wcen_o
);
  localparam int WP_W = PIX_W + COEF_W;
  localparam logic [COEF_W-1:0] COEF_MAX = {COEF_W{1'b1}};

  logic [PIX_W-1:0] cen_q, cen_a;
  logic [WP_W-1:0]  wc_q [DEPTH-1];
  logic [DEPTH-1:0] vld_q;

  assign cen_o = (valid_i && first_i) ? center_i : cen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q <= '0;
      cen_a <= '0;
      vld_q <= '0;
    end else begin
      if (valid_i && first_i) cen_q <= center_i;
      cen_a <= cen_o;
      vld_q <= {vld_q[DEPTH-2:0], valid_i};
    end
  end

  for (genvar s = 0; s < DEPTH - 1; s++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     wc_q[s] <= '0;
      else if (s == 0) wc_q[s] <= WP_W'(cen_a) * WP_W'(COEF_MAX);
      else             wc_q[s] <= wc_q[s-1];
    end
  end

  assign wcen_o  = wc_q[DEPTH-2];
  assign valid_o = vld_q[DEPTH-1];

  assert_wcen_scale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((wcen_o % WP_W'(COEF_MAX)) == '0));
endmodule

// File: rtl/range_weight_pipe.sv
module range_weight_pipe #(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 8,
  parameter int N_GRP     = 6,
  parameter int LUT_SHIFT = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic                              first_i,
  input  logic [PIX_W-1:0]                  center_i,
  input  logic [N_GRP*PIX_W-1:0]            grp_pix_i,
  output logic                              valid_o,
  output logic [N_GRP*(PIX_W+COEF_W)-1:0]   wpix_o,
  output logic [N_GRP*COEF_W-1:0]           coef_o,
  output logic [PIX_W+COEF_W-1:0]           wcen_o,
  output logic [COEF_W-1:0]                 cen_coef_o
);
  localparam int WP_W  = PIX_W + COEF_W;
  localparam int LAT   = 4;

  logic [PIX_W-1:0] cen_eff;

  rwp_centre #(.PIX_W(PIX_W), .COEF_W(COEF_W), .DEPTH(LAT)) u_cen (
    .clk_i, .rst_ni, .valid_i, .first_i, .center_i,
    .cen_o(cen_eff), .valid_o, .wcen_o
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_lane
    rwp_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W), .LUT_SHIFT(LUT_SHIFT)) u_lane (
      .clk_i, .rst_ni,
      .pix_i  (grp_pix_i[g*PIX_W +: PIX_W]),
      .cen_i  (cen_eff),
      .wpix_o (wpix_o[g*WP_W +: WP_W]),
      .coef_o (coef_o[g*COEF_W +: COEF_W])
    );
  end

  assign cen_coef_o = {COEF_W{1'b1}};

  assert_valid_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, LAT));
  assert_cen_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !first_i && $past(valid_i)) |-> (cen_eff == $past(cen_eff)));
endmodule

// File: tb/sim_range_weight_pipe.sv
module sim_range_weight_pipe;
  localparam int NG = 6, PW = 8, CW = 8, WPW = 16;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0, first_i = 0;
  logic [PW-1:0] center_i = '0;
  logic [NG*PW-1:0] grp_pix_i = '0;
  logic valid_o;
  logic [NG*WPW-1:0] wpix_o;
  logic [NG*CW-1:0] coef_o;
  logic [WPW-1:0] wcen_o;
  logic [CW-1:0] cen_coef_o;

  range_weight_pipe u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .first_i, .center_i, .grp_pix_i,
    .valid_o, .wpix_o, .coef_o, .wcen_o, .cen_coef_o
  );

  always #2ns clk = ~clk;

  typedef struct {
    int cyc; logic [WPW-1:0] wp [NG]; logic [CW-1:0] cf [NG];
    logic [WPW-1:0] wc; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [PW-1:0] pat [4][NG];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_coef(int d);
    if (d / 16 >= 8) return 0;
    return 255 >> (d / 16);
  endfunction

  task automatic drive_slot(logic fst, logic [PW-1:0] cin, logic [PW-1:0] ctrue,
                            logic [PW-1:0] px [NG], string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1; first_i = fst; center_i = cin;
    for (int g = 0; g < NG; g++) begin
      int d;
      grp_pix_i[g*PW +: PW] = px[g];
      d = (px[g] >= ctrue) ? px[g] - ctrue : ctrue - px[g];
      e.cf[g] = CW'(ref_coef(d));
      e.wp[g] = WPW'(px[g]) * WPW'(e.cf[g]);
    end
    e.wc = WPW'(ctrue) * 16'd255;
    e.cyc = cyc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); valid_i = 0; first_i = 0; center_i = PW'($urandom);
    end
  endtask

  // slots 1..3 carry a junk centre on center_i (R1)
  task automatic window(logic [PW-1:0] cen, string tag);
    for (int s = 0; s < 4; s++)
      drive_slot(s == 0, (s == 0) ? cen : PW'($urandom), cen, pat[s], tag);
  endtask

  task automatic chk(bit ok, string req, string tag, logic [WPW-1:0] act, logic [WPW-1:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) act=%0d exp=%0d", req, tag, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) chk(0, "R6", "unexpected valid_o", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc + 4, "R6", e.tag, WPW'(cyc), WPW'(e.cyc + 4));
        for (int g = 0; g < NG; g++) begin
          chk(coef_o[g*CW +: CW] == e.cf[g], "R3/R9 coef", e.tag,
              WPW'(coef_o[g*CW +: CW]), WPW'(e.cf[g]));
          chk(wpix_o[g*WPW +: WPW] == e.wp[g], "R4/R9 wpix", e.tag,
              wpix_o[g*WPW +: WPW], e.wp[g]);
        end
        chk(wcen_o == e.wc, "R5 wcen", e.tag, wcen_o, e.wc);
        chk(cen_coef_o == 8'd255, "R5 cen coef", e.tag, WPW'(cen_coef_o), 16'd255);
      end
    end
  end

  initial begin
    if (cyc > 50000) ;
    forever begin
      @(posedge clk);
      if (cyc > 50000) begin
        fails++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(valid_o == 0 && wpix_o == '0 && coef_o == '0 && wcen_o == '0, "R8", "reset",
        WPW'(valid_o), 0);
    rst_n = 1;
    idle(2);
    chk(valid_o == 0, "R8", "after release", WPW'(valid_o), 0);

    // R3: equal to centre -> full scale
    for (int s = 0; s < 4; s++) for (int g = 0; g < NG; g++) pat[s][g] = 8'd100;
    window(8'd100, "R3 equal");
    idle(3);

    // R2: mirrored distances around 128
    for (int g = 0; g < NG; g++) begin
      int dl [NG] = '{1, 15, 16, 40, 100, 127};
      pat[0][g] = PW'(128 + dl[g]); pat[1][g] = PW'(128 - dl[g]);
      pat[2][g] = PW'(128 - dl[g]); pat[3][g] = PW'(128 + dl[g] - 1);
    end
    window(8'd128, "R2 mirror");

    // R3 edges: beyond last step, both extremes
    for (int s = 0; s < 4; s++) for (int g = 0; g < NG; g++) pat[s][g] = 8'd255;
    window(8'd0, "R3 far high");
    for (int s = 0; s < 4; s++) for (int g = 0; g < NG; g++) pat[s][g] = 8'd0;
    window(8'd255, "R3 far low");
    for (int s = 0; s < 4; s++) for (int g = 0; g < NG; g++) pat[s][g] = PW'(112 + 16 * s + g);
    window(8'd0, "R3 step edges");
    idle(1);

    // R1: junk centre on later slots, distinct lanes (R9)
    for (int s = 0; s < 4; s++) for (int g = 0; g < NG; g++) pat[s][g] = PW'(50 + 7 * g - 3 * s);
    window(8'd50, "R1 hold");
    idle(2);

    // R7: back-to-back random windows
    for (int w = 0; w < 20; w++) begin
      for (int s = 0; s < 4; s++) for (int g = 0; g < NG; g++) pat[s][g] = PW'($urandom);
      window(PW'($urandom), "R7 stream");
    end
    idle(8);
    chk(q.size() == 0, "R6", "drain", WPW'(q.size()), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule